// File: doc/BRIEF.md
# Carry-Flag Bit Manipulation Unit

This unit executes the single-bit instructions of a small 8-bit processor. Each instruction arrives already decoded: an operation code, a 3-bit bit index, a source selector and an address. The unit holds the accumulator and the status byte. It reaches special-function registers and data memory through a simple request/ready port that can be stalled by wait states.

There are three kinds of operation. The first ANDs, ORs or XORs one selected operand bit into the carry and leaves the operand alone. The second forces one operand bit to 1 or 0 by read-modify-write. The third acts on the carry alone, to set, clear or invert it. The number of clocks an instruction takes depends on its source. For memory operands it also depends on whether the address lies in the fast internal RAM window, and on how many wait cycles the memory inserts. A one-clock `done` pulse marks retirement. An operation/source pair that makes no sense raises `err` for one clock and changes nothing.

A sequencer with six states drives the work:
- IDLE accepts `start`. From IDLE it goes to FAULT on an invalid pair, to READ for a memory operand, to PAD for a register operand, and straight to RETIRE for a carry-only operation.
- READ holds the read request until ready. It then moves to PAD, or to WRITE or RETIRE when no padding is due.
- PAD waits a fixed number of clocks and then moves to WRITE for a memory set/clear, otherwise to RETIRE.
- WRITE holds the write request until ready and then moves to RETIRE.
- RETIRE pulses `done`, commits the register results and returns to IDLE.
- FAULT pulses `err` and returns to IDLE.

Top module: `cybit_unit`

## Requirements
- R1: Operations 0 (AND), 1 (OR) and 2 (XOR) combine bit `bit_sel` of the operand into the carry (status bit 0) with that logic function. The operand byte is not changed, and no memory write is issued.
- R2: Operations 3 (set bit) and 4 (clear bit) write 1 or 0 into the selected bit of the operand. The other seven bits keep their values. This applies to accumulator, status-byte and memory operands alike.
- R3: Operations 5, 6 and 7 set, clear and invert the carry. They require source 0 (none) and retire with `done` in clock 2, counting the `start` clock as clock 1.
- R4: The status byte keeps the carry in bit 0, the auxiliary carry in bit 4 and the zero flag in bit 6. A set or clear on source 2 (status byte) therefore changes these flags directly.
- R5: Logic and set/clear operations on source 1 (accumulator) or source 2 (status byte) retire in clock 4.
- R6: Logic operations on sources 4 (short direct) and 5 (pointer) retire in clock 6 when `addr` is inside [FAST_LO, FAST_HI]. Outside that window they retire in clock 7+n, where n is the number of read wait cycles. Source 3 (special-function register) always uses the slow timing.
- R7: Set/clear on memory sources retires in clock 6+n+m inside the fast window, where m is the number of write wait cycles. Outside the window it retires in clock 8+n+m. The new byte is written back to the same address.
- R8: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ready` is high. Each clock of wait adds one clock to the instruction.
- R9: `done` is high for exactly one clock per accepted valid instruction.
- R10: An invalid pair is rejected with a one-clock `err` in clock 2. Invalid pairs are a logic or set/clear operation with source 0, 6 or 7, and a carry-only operation with any source other than 0. A rejected instruction raises no `done`, issues no memory access and changes neither register.
- R11: Reset clears the accumulator, the status byte, `done`, `err` and `mem_req`. While the unit is idle and `start` is low, `ld_acc` and `ld_psw` load `ld_data` into the accumulator or the status byte at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (honoured in IDLE) |
| op | input | 3 | Operation code (R1, R2, R3) |
| bit_sel | input | 3 | Index of the operand bit |
| src | input | 3 | Operand source selector |
| addr | input | 16 | Memory or special-function register address |
| ld_acc | input | 1 | Load accumulator from ld_data |
| ld_psw | input | 1 | Load status byte from ld_data |
| ld_data | input | 8 | Load value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory access completes this clock |
| done | output | 1 | Instruction retires |
| err | output | 1 | Instruction rejected |
| acc_q | output | 8 | Accumulator |
| psw_q | output | 8 | Status byte (carry in bit 0) |

## Verification
Each result is due a fixed number of clocks after `start`, and that number follows from R3, R5, R6 and R7 together with the wait counts the memory model is set to. The bench counts clocks from the `start` clock, sampling at falling edges. It compares the clock in which `done` (or `err`) first appears with the required number. Register values are read one falling edge later, after the retiring edge has committed them. The memory byte and its write count are checked at that same point.

// File: rtl/cybit_pkg.sv
package cybit_pkg;
    localparam logic [2:0] OP_AND  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_XOR  = 3'd2;
    localparam logic [2:0] OP_SETB = 3'd3;
    localparam logic [2:0] OP_CLRB = 3'd4;
    localparam logic [2:0] OP_SETC = 3'd5;
    localparam logic [2:0] OP_CLRC = 3'd6;
    localparam logic [2:0] OP_NOTC = 3'd7;

    localparam logic [2:0] SRC_NONE = 3'd0;
    localparam logic [2:0] SRC_ACC  = 3'd1;
    localparam logic [2:0] SRC_PSW  = 3'd2;
    localparam logic [2:0] SRC_SFR  = 3'd3;
    localparam logic [2:0] SRC_DIR  = 3'd4;
    localparam logic [2:0] SRC_PTR  = 3'd5;

    localparam int FLAG_CY = 0;

    // padding clocks spent in ST_PAD per instruction class
    localparam int PAD_REG        = 2;
    localparam int PAD_LOGIC_FAST = 3;
    localparam int PAD_LOGIC_SLOW = 4;
    localparam int PAD_RMW_FAST   = 2;
    localparam int PAD_RMW_SLOW   = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_PAD, ST_WRITE, ST_RETIRE, ST_FAULT
    } seq_st_e;
endpackage

// File: rtl/cybit_plan.sv
module cybit_plan
    import cybit_pkg::*;
#(
    parameter int             AW      = 16,
    parameter logic [AW-1:0]  FAST_LO = 'hFB00,
    parameter logic [AW-1:0]  FAST_HI = 'hFEFF,
    parameter int             PW      = 3
) (
    input  logic [2:0]    op,
    input  logic [2:0]    src,
    input  logic [AW-1:0] addr,
    output logic          valid,
    output logic          mem_use,
    output logic          mem_rmw,
    output logic [PW-1:0] pad
);
    logic logic_op, bit_op, cy_op, reg_src, mem_src, fast;

    always_comb begin
        logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        bit_op   = (op == OP_SETB) || (op == OP_CLRB);
        cy_op    = !logic_op && !bit_op;
        reg_src  = (src == SRC_ACC) || (src == SRC_PSW);
        mem_src  = (src == SRC_SFR) || (src == SRC_DIR) || (src == SRC_PTR);
        fast     = (src != SRC_SFR) && (addr >= FAST_LO) && (addr <= FAST_HI);
        valid    = cy_op ? (src == SRC_NONE) : (reg_src || mem_src);
        mem_use  = valid && !cy_op && mem_src;
        mem_rmw  = mem_use && bit_op;
        if (cy_op)
            pad = '0;
        else if (reg_src)
            pad = PW'(PAD_REG);
        else if (bit_op)
            pad = fast ? PW'(PAD_RMW_FAST) : PW'(PAD_RMW_SLOW);
        else
            pad = fast ? PW'(PAD_LOGIC_FAST) : PW'(PAD_LOGIC_SLOW);
    end
endmodule

// File: rtl/cybit_alu.sv
module cybit_alu
    import cybit_pkg::*;
#(
    parameter  int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic [2:0]    op,
    input  logic [BW-1:0] bidx,
    input  logic [DW-1:0] operand,
    input  logic          cy,
    output logic          cy_next,
    output logic [DW-1:0] byte_next
);
    logic sel;
    assign sel = operand[bidx];

    always_comb begin
        case (op)
            OP_AND:  cy_next = cy & sel;
            OP_OR:   cy_next = cy | sel;
            OP_XOR:  cy_next = cy ^ sel;
            OP_SETC: cy_next = 1'b1;
            OP_CLRC: cy_next = 1'b0;
            OP_NOTC: cy_next = ~cy;
            default: cy_next = cy;
        endcase
    end

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign byte_next[g] = (bidx != BW'(g)) ? operand[g] :
                              (op == OP_SETB)  ? 1'b1 :
                              (op == OP_CLRB)  ? 1'b0 : operand[g];
    end
endmodule

// File: rtl/cybit_fsm.sv
module cybit_fsm
    import cybit_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          valid,
    input  logic          mem_use,
    input  logic          mem_rmw,
    input  logic [PW-1:0] pad,
    input  logic          mem_ready,
    output logic          idle,
    output logic          accept,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we
);
    seq_st_e       st, nxt;
    logic          rmw_q;
    logic [PW-1:0] pad_q, cnt_q;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:
                if (start) begin
                    if (!valid)        nxt = ST_FAULT;
                    else if (mem_use)  nxt = ST_READ;
                    else if (pad != 0) nxt = ST_PAD;
                    else               nxt = ST_RETIRE;
                end
            ST_READ:
                if (mem_ready)
                    nxt = (pad_q != 0) ? ST_PAD : (rmw_q ? ST_WRITE : ST_RETIRE);
            ST_PAD:
                if (cnt_q == 0) nxt = rmw_q ? ST_WRITE : ST_RETIRE;
            ST_WRITE:
                if (mem_ready) nxt = ST_RETIRE;
            ST_RETIRE, ST_FAULT:
                nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmw_q <= 1'b0;
            pad_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            rmw_q <= mem_rmw;
            pad_q <= pad;
            cnt_q <= pad - PW'(1);
        end else if (st == ST_READ && mem_ready) begin
            cnt_q <= pad_q - PW'(1);
        end else if (st == ST_PAD) begin
            cnt_q <= cnt_q - PW'(1);
        end
    end

    always_comb begin
        idle    = (st == ST_IDLE);
        accept  = idle && start;
        done    = (st == ST_RETIRE);
        err     = (st == ST_FAULT);
        mem_req = (st == ST_READ) || (st == ST_WRITE);
        mem_we  = (st == ST_WRITE);
    end

    // R9: retirement is a single-clock pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a completed write retires on the following clock
    a_r7_write_then_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> done);
endmodule

// File: rtl/cybit_unit.sv
module cybit_unit
    import cybit_pkg::*;
#(
    parameter int             AW      = 16,
    parameter int             DW      = 8,
    parameter logic [AW-1:0]  FAST_LO = 'hFB00,
    parameter logic [AW-1:0]  FAST_HI = 'hFEFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [$clog2(DW)-1:0] bit_sel,
    input  logic [2:0]    src,
    input  logic [AW-1:0] addr,
    input  logic          ld_acc,
    input  logic          ld_psw,
    input  logic [DW-1:0] ld_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] psw_q
);
    localparam int BW = $clog2(DW);
    localparam int PW = 3;

    logic          valid, mem_use, mem_rmw, idle, accept, cy_next;
    logic [PW-1:0] pad;
    logic [2:0]    op_q, src_q;
    logic [BW-1:0] bidx_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rdata_q, operand, byte_next;

    cybit_plan #(.AW(AW), .FAST_LO(FAST_LO), .FAST_HI(FAST_HI), .PW(PW)) u_plan (
        .op(op), .src(src), .addr(addr),
        .valid(valid), .mem_use(mem_use), .mem_rmw(mem_rmw), .pad(pad)
    );

    cybit_fsm #(.PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
        .mem_use(mem_use), .mem_rmw(mem_rmw), .pad(pad), .mem_ready(mem_ready),
        .idle(idle), .accept(accept), .done(done), .err(err),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    always_comb begin
        if (src_q == SRC_ACC)      operand = acc_q;
        else if (src_q == SRC_PSW) operand = psw_q;
        else                       operand = rdata_q;
    end

    cybit_alu #(.DW(DW)) u_alu (
        .op(op_q), .bidx(bidx_q), .operand(operand), .cy(psw_q[FLAG_CY]),
        .cy_next(cy_next), .byte_next(byte_next)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = byte_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            src_q   <= '0;
            bidx_q  <= '0;
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= op;
                src_q  <= src;
                bidx_q <= bit_sel;
                addr_q <= addr;
            end
            if (mem_req && !mem_we && mem_ready)
                rdata_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            psw_q <= '0;
        end else if (idle && !start) begin
            if (ld_acc) acc_q <= ld_data;
            if (ld_psw) psw_q <= ld_data;
        end else if (done) begin
            if (op_q == OP_SETB || op_q == OP_CLRB) begin
                if (src_q == SRC_ACC)      acc_q <= byte_next;
                else if (src_q == SRC_PSW) psw_q <= byte_next;
            end else begin
                psw_q[FLAG_CY] <= cy_next;
            end
        end
    end

    // R8: a stalled request keeps its address and direction
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R1: only set/clear instructions ever write memory
    a_r1_logic_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op_q == OP_SETB || op_q == OP_CLRB));
    // R3: clear-carry leaves carry at zero after retiring
    a_r3_clrc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_CLRC) |=> !psw_q[FLAG_CY]);
    // R10: a rejected instruction leaves both registers alone
    a_r10_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> ($stable(acc_q) && $stable(psw_q)));
endmodule

// File: tb/cybit_unit_test.sv
module cybit_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0, bit_sel = '0, src = '0;
    logic [15:0] addr = '0;
    logic        ld_acc = 1'b0, ld_psw = 1'b0;
    logic [7:0]  ld_data = '0;
    logic        mem_req, mem_we, mem_ready, done, err;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, acc_q, psw_q;

    int total = 0;
    int bad = 0;

    // memory model: one byte, programmable wait counts
    logic [7:0]  mbyte;
    logic [15:0] waddr;
    int          wc, nwrites, nreq;
    int          rwait = 0, wwait = 0;
    logic        mb_load = 1'b0;
    logic [7:0]  mb_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cybit_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_sel(bit_sel),
        .src(src), .addr(addr), .ld_acc(ld_acc), .ld_psw(ld_psw), .ld_data(ld_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done), .err(err),
        .acc_q(acc_q), .psw_q(psw_q)
    );

    assign mem_rdata = mbyte;
    assign mem_ready = mem_req && (wc == (mem_we ? wwait : rwait));

    always @(posedge clk) begin
        if (mb_load) begin
            mbyte   <= mb_val;
            nwrites <= 0;
            nreq    <= 0;
            wc      <= 0;
            waddr   <= '0;
        end else begin
            if (mem_req && !mem_ready) wc <= wc + 1;
            else                       wc <= 0;
            if (mem_req) nreq <= nreq + 1;
            if (mem_req && mem_we && mem_ready) begin
                mbyte   <= mem_wdata;
                nwrites <= nwrites + 1;
                waddr   <= mem_addr;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic preset(input logic [7:0] a, input logic [7:0] p);
        @(negedge clk); ld_data = a; ld_acc = 1'b1;
        @(negedge clk); ld_acc = 1'b0; ld_data = p; ld_psw = 1'b1;
        @(negedge clk); ld_psw = 1'b0;
    endtask

    task automatic mem_setup(input logic [7:0] v, input int rw, input int ww);
        @(negedge clk); mb_val = v; mb_load = 1'b1; rwait = rw; wwait = ww;
        @(negedge clk); mb_load = 1'b0;
    endtask

    // cycles are counted with the start clock as clock 1
    task automatic run(input logic [2:0] o, input logic [2:0] b, input logic [2:0] s,
                       input logic [15:0] a, output int cyc, output logic d, output logic e);
        @(negedge clk);
        op = o; bit_sel = b; src = s; addr = a; start = 1'b1;
        cyc = 1; d = 1'b0; e = 1'b0;
        while (cyc < 64) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) begin d = 1'b1; break; end
            if (err)  begin e = 1'b1; break; end
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 reset acc", int'(acc_q), 0);
        chk("R11 reset psw", int'(psw_q), 0);
        chk("R11 reset done/err/req", int'({done, err, mem_req}), 0);
        preset(8'h3C, 8'h50);
        chk("R11 load acc", int'(acc_q), 8'h3C);
        chk("R11 load psw", int'(psw_q), 8'h50);
    endtask

    task automatic t_carry_only();
        int c; logic d, e;
        preset(8'h00, 8'h00);
        run(3'd5, 3'd0, 3'd0, 16'h0, c, d, e);
        chk("R3 setc clocks", c, 2);
        chk("R3 setc value", int'(psw_q), 8'h01);
        run(3'd7, 3'd0, 3'd0, 16'h0, c, d, e);
        chk("R3 notc 1->0", int'(psw_q), 8'h00);
        run(3'd7, 3'd0, 3'd0, 16'h0, c, d, e);
        chk("R3 notc 0->1", int'(psw_q), 8'h01);
        chk("R9 done seen", int'(d), 1);
        run(3'd6, 3'd0, 3'd0, 16'h0, c, d, e);
        chk("R3 clrc clocks", c, 2);
        chk("R3 clrc value", int'(psw_q), 8'h00);
    endtask

    task automatic t_acc_logic();
        int c; logic d, e;
        preset(8'hA5, 8'h00);
        run(3'd1, 3'd2, 3'd1, 16'h0, c, d, e);
        chk("R5 acc logic clocks", c, 4);
        chk("R1 or acc bit2", int'(psw_q[0]), 1);
        run(3'd0, 3'd1, 3'd1, 16'h0, c, d, e);
        chk("R1 and acc bit1", int'(psw_q[0]), 0);
        run(3'd2, 3'd0, 3'd1, 16'h0, c, d, e);
        chk("R1 xor acc bit0", int'(psw_q[0]), 1);
        run(3'd2, 3'd5, 3'd1, 16'h0, c, d, e);
        chk("R1 xor acc bit5", int'(psw_q[0]), 0);
        chk("R1 acc untouched", int'(acc_q), 8'hA5);
    endtask

    task automatic t_acc_bits();
        int c; logic d, e;
        preset(8'hA5, 8'h00);
        run(3'd3, 3'd1, 3'd1, 16'h0, c, d, e);
        chk("R5 acc set clocks", c, 4);
        chk("R2 set acc bit1", int'(acc_q), 8'hA7);
        run(3'd4, 3'd7, 3'd1, 16'h0, c, d, e);
        chk("R2 clr acc bit7", int'(acc_q), 8'h27);
        chk("R2 psw untouched", int'(psw_q), 8'h00);
    endtask

    task automatic t_psw_bits();
        int c; logic d, e;
        preset(8'h00, 8'h00);
        run(3'd3, 3'd6, 3'd2, 16'h0, c, d, e);
        chk("R4 set zero flag", int'(psw_q), 8'h40);
        run(3'd3, 3'd0, 3'd2, 16'h0, c, d, e);
        chk("R4 set carry via psw", int'(psw_q), 8'h41);
        run(3'd0, 3'd6, 3'd2, 16'h0, c, d, e);
        chk("R5 psw logic clocks", c, 4);
        chk("R1 and psw bit6", int'(psw_q), 8'h41);
        run(3'd4, 3'd0, 3'd2, 16'h0, c, d, e);
        chk("R4 clear carry via psw", int'(psw_q), 8'h40);
        run(3'd1, 3'd4, 3'd2, 16'h0, c, d, e);
        chk("R4 or with aux carry 0", int'(psw_q), 8'h40);
    endtask

    task automatic t_mem_logic();
        int c; logic d, e;
        preset(8'h00, 8'h00);
        mem_setup(8'h08, 0, 0);
        run(3'd1, 3'd3, 3'd4, 16'hFC10, c, d, e);
        chk("R6 fast logic clocks", c, 6);
        chk("R1 or mem bit3", int'(psw_q[0]), 1);
        chk("R1 no mem write", nwrites, 0);
        chk("R1 mem byte kept", int'(mbyte), 8'h08);
        mem_setup(8'h08, 3, 0);
        run(3'd0, 3'd3, 3'd4, 16'h0200, c, d, e);
        chk("R6 slow logic clocks n=3", c, 7 + 3);
        chk("R1 and mem bit3", int'(psw_q[0]), 1);
        run(3'd2, 3'd3, 3'd5, 16'h0200, c, d, e);
        chk("R8 slow xor clocks n=3", c, 7 + 3);
        chk("R1 xor mem bit3", int'(psw_q[0]), 0);
        mem_setup(8'h08, 0, 0);
        run(3'd1, 3'd3, 3'd5, 16'hFEFF, c, d, e);
        chk("R6 fast window top clocks", c, 6);
        run(3'd1, 3'd0, 3'd3, 16'hFC20, c, d, e);
        chk("R6 sfr slow clocks", c, 7);
    endtask

    task automatic t_mem_rmw();
        int c; logic d, e;
        preset(8'h00, 8'h00);
        mem_setup(8'h00, 0, 0);
        run(3'd3, 3'd5, 3'd5, 16'hFB00, c, d, e);
        chk("R7 fast set clocks", c, 6);
        chk("R7 fast set byte", int'(mbyte), 8'h20);
        chk("R7 one write", nwrites, 1);
        chk("R7 write address", int'(waddr), 16'hFB00);
        mem_setup(8'hFF, 2, 1);
        run(3'd4, 3'd0, 3'd5, 16'hFF00, c, d, e);
        chk("R7 slow clr clocks n=2 m=1", c, 8 + 2 + 1);
        chk("R2 clr mem bit0", int'(mbyte), 8'hFE);
        mem_setup(8'h0F, 1, 2);
        run(3'd3, 3'd7, 3'd3, 16'hFC30, c, d, e);
        chk("R8 sfr set clocks n=1 m=2", c, 8 + 1 + 2);
        chk("R2 set sfr bit7", int'(mbyte), 8'h8F);
    endtask

    task automatic t_invalid();
        int c; logic d, e;
        preset(8'h5A, 8'h01);
        mem_setup(8'h33, 0, 0);
        run(3'd0, 3'd2, 3'd0, 16'hFC10, c, d, e);
        chk("R10 and/none err clock", c, 2);
        chk("R10 err not done", int'({e, d}), 2);
        run(3'd3, 3'd2, 3'd6, 16'hFC10, c, d, e);
        chk("R10 set/src6 err", int'({e, d}), 2);
        run(3'd5, 3'd0, 3'd1, 16'hFC10, c, d, e);
        chk("R10 setc/acc err", int'({e, d}), 2);
        chk("R10 acc unchanged", int'(acc_q), 8'h5A);
        chk("R10 psw unchanged", int'(psw_q), 8'h01);
        chk("R10 no memory access", nreq, 0);
        chk("R10 memory byte kept", int'(mbyte), 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry_only();
        t_acc_logic();
        t_acc_bits();
        t_psw_bits();
        t_mem_logic();
        t_mem_rmw();
        t_invalid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule